// File: doc/BRIEF.md
# Byte FIFO Data Port with Request/Acknowledge Handshake

This block is the data-transfer side of a storage bus controller. A 16-byte FIFO sits between the host and a device-side byte stream. The host can reach the FIFO in two ways. The first is as an ordinary register, using chip select and a 4-bit register address. The second is through a dedicated port that is selected by an active-low acknowledge input and paced by a request output.

Each programmed register access to the FIFO raises an interrupt. Accesses through the acknowledge port do not. They are counted by a loadable 16-bit transfer counter, and an interrupt is raised only when that counter runs out or when the device side signals a phase change.

A control bit picks the transfer direction, and the host sets it before loading the counter. In device-to-host mode the device stream fills the FIFO and the host drains it. In host-to-device mode the host fills the FIFO and the device stream drains it. Interrupt causes are held in a status register until the host reads it. Bad accesses set sticky error bits in the same register.

Top module: `xfer_port`

## Requirements
- R1: The FIFO stores up to 16 bytes and returns them in the order they were written.
- R2: With the direction bit (bit 0 of register 3) at 0, the device stream writes into the FIFO. `dev_in_ready` is high when the FIFO is not full and the host is not writing the FIFO in the same cycle. `dreq` is high exactly when at least one byte is stored.
- R3: With the direction bit at 1, `dreq` is high exactly when the FIFO has room for another byte. `dev_out_valid` is high when a byte is stored and the host is not reading the FIFO in the same cycle, and `dev_out_data` then shows the oldest byte.
- R4: With `dack_n` low and `cs` low, a read returns the oldest byte on `rdata` in the same cycle and removes it, and a write stores `wdata`. If `cs` and `dack_n` are both active, no FIFO access takes place and status bit 6 is set.
- R5: With `cs` high and `dack_n` high, register address 2 reads or writes the FIFO. Each such access that is accepted latches interrupt cause code 1.
- R6: Writing register 0 loads the low byte of the transfer counter and writing register 1 loads the high byte; both bytes read back at the same addresses. Each accepted acknowledge-port access decrements the counter by one, and the counter holds at zero.
- R7: A decrement that takes the counter from 1 to 0 latches cause code 2 and asserts `irq` from the next cycle on.
- R8: `phase_chg` high at a clock edge latches cause code 3. When causes arrive together, the highest code is kept, and a lower code never replaces a higher latched one.
- R9: Register 4 reads as the status byte: bits 1:0 hold the cause code, bit 7 the FIFO error flag and bit 6 the select-clash flag. Reading it clears all of these and drops `irq` on the next cycle, unless a new cause arrives in that same cycle.
- R10: A read of an empty FIFO or a write to a full FIFO, on either path, is ignored. It leaves the FIFO and the counter unchanged and sets status bit 7.
- R11: After reset the FIFO is empty, the counter and the direction bit are 0, the status byte is 0, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Register chip select, active high |
| reg_addr | input | 4 | Register address |
| rd | input | 1 | Host read strobe |
| wr | input | 1 | Host write strobe (ignored while rd is high) |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, valid in the cycle of the read |
| dack_n | input | 1 | Acknowledge-port select, active low |
| dreq | output | 1 | Request: the FIFO is ready for an acknowledge-port access |
| dev_in_valid | input | 1 | Device byte offered to the FIFO |
| dev_in_data | input | 8 | Device byte |
| dev_in_ready | output | 1 | FIFO accepts the device byte |
| dev_out_valid | output | 1 | FIFO byte offered to the device |
| dev_out_data | output | 8 | Oldest FIFO byte |
| dev_out_ready | input | 1 | Device takes the offered byte |
| phase_chg | input | 1 | Phase-change event, one per high cycle |
| irq | output | 1 | Interrupt, high while a cause is latched |

## Verification
The assertions assume that the host does not raise `rd` and `wr` together, and that `phase_chg` is sampled as one event per high cycle. The FIFO assertion also assumes that the enclosing logic never pushes into a full FIFO, which the top-level gating guarantees. The stimulus drives every input at the falling edge, keeps `rd` and `wr` exclusive, and raises the select clash only on purpose. It deliberately overfills and over-drains the FIFO on both paths to exercise the error flag.

// File: rtl/xfp_pkg.sv
package xfp_pkg;

    localparam int DATA_W     = 8;
    localparam int FIFO_DEPTH = 16;
    localparam int CNT_W      = 2 * DATA_W;
    localparam int RADDR_W    = 4;

    localparam logic [RADDR_W-1:0] RA_CNT_LO = 4'd0;
    localparam logic [RADDR_W-1:0] RA_CNT_HI = 4'd1;
    localparam logic [RADDR_W-1:0] RA_FIFO   = 4'd2;
    localparam logic [RADDR_W-1:0] RA_CTRL   = 4'd3;
    localparam logic [RADDR_W-1:0] RA_STAT   = 4'd4;

    // Interrupt cause codes; a larger code has higher priority.
    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_PIO   = 2'd1,
        CAUSE_DONE  = 2'd2,
        CAUSE_PHASE = 2'd3
    } cause_e;

    typedef struct packed {
        logic clash;   // chip select and acknowledge both active
        logic dma;     // acknowledge-port access
        logic regs;    // register-file access
    } host_sel_t;

    function automatic host_sel_t decode_sel(input logic cs, input logic dack_n);
        host_sel_t s;
        s.clash = cs & ~dack_n;
        s.dma   = ~cs & ~dack_n;
        s.regs  = cs & dack_n;
        return s;
    endfunction

    function automatic cause_e cause_max(input cause_e a, input cause_e b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/xfp_fifo.sv
module xfp_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] pdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q    <= '0;
            rp_q    <= '0;
            level_q <= '0;
        end else begin
            if (push) wp_q <= wp_q + 1'b1;
            if (pop)  rp_q <= rp_q + 1'b1;
            if (push && !pop)      level_q <= level_q + 1'b1;
            else if (pop && !push) level_q <= level_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp_q] <= pdata;
    end

    assign head  = mem[rp_q];
    assign full  = (level_q == (AW+1)'(DEPTH));
    assign empty = (level_q == '0);

    // R1
    fill_step_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> (level_q == $past(level_q) + 1'b1));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> !push || pop);

endmodule

// File: rtl/xfp_xcount.sv
module xfp_xcount #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_lo,
    input  logic           load_hi,
    input  logic [W/2-1:0] din,
    input  logic           dec,
    output logic [W-1:0]   cnt,
    output logic           tc
);
    localparam int H = W / 2;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                          cnt_q <= '0;
        else if (load_lo)                 cnt_q[H-1:0] <= din;
        else if (load_hi)                 cnt_q[W-1:H] <= din;
        else if (dec && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
    end

    assign cnt = cnt_q;
    assign tc  = dec && (cnt_q == W'(1));

    // R6
    count_down_chk: assert property (@(posedge clk) disable iff (rst)
        (dec && !load_lo && !load_hi && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R6
    hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !load_lo && !load_hi) |=> (cnt_q == '0));

endmodule

// File: rtl/xfp_irq.sv
module xfp_irq
    import xfp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   phase_i,
    input  logic   tc_i,
    input  logic   pio_i,
    input  logic   clr_i,
    input  logic   ovf_i,
    input  logic   clash_i,
    output cause_e cause,
    output logic   err_fifo,
    output logic   err_clash,
    output logic   irq
);
    cause_e new_c, cause_q;
    logic   errf_q, errc_q;

    always_comb begin
        if (phase_i)    new_c = CAUSE_PHASE;
        else if (tc_i)  new_c = CAUSE_DONE;
        else if (pio_i) new_c = CAUSE_PIO;
        else            new_c = CAUSE_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= CAUSE_NONE;
            errf_q  <= 1'b0;
            errc_q  <= 1'b0;
        end else begin
            cause_q <= clr_i ? new_c : cause_max(cause_q, new_c);
            errf_q  <= (errf_q && !clr_i) || ovf_i;
            errc_q  <= (errc_q && !clr_i) || clash_i;
        end
    end

    assign cause     = cause_q;
    assign err_fifo  = errf_q;
    assign err_clash = errc_q;
    assign irq       = (cause_q != CAUSE_NONE);

    // R8
    phase_wins_chk: assert property (@(posedge clk) disable iff (rst)
        phase_i |=> (cause_q == CAUSE_PHASE));

    // R7
    done_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (tc_i && !phase_i) |=> (irq && cause_q >= CAUSE_DONE));

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !phase_i && !tc_i && !pio_i) |=> !irq);

    // R4
    clash_flag_chk: assert property (@(posedge clk) disable iff (rst)
        clash_i |=> err_clash);

endmodule

// File: rtl/xfer_port.sv
module xfer_port
    import xfp_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs,
    input  logic [RADDR_W-1:0]  reg_addr,
    input  logic                rd,
    input  logic                wr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic                dack_n,
    output logic                dreq,
    input  logic                dev_in_valid,
    input  logic [DATA_W-1:0]   dev_in_data,
    output logic                dev_in_ready,
    output logic                dev_out_valid,
    output logic [DATA_W-1:0]   dev_out_data,
    input  logic                dev_out_ready,
    input  logic                phase_chg,
    output logic                irq
);
    host_sel_t          sel;
    logic               wr_s, fifo_hit, rd_req, wr_req;
    logic               host_pop, host_push, dev_push, dev_pop, ovf;
    logic               f_push, f_pop, f_full, f_empty;
    logic [DATA_W-1:0]  f_head, f_pdata;
    logic               dir_q, dma_ok, pio_ok, stat_clr, tc;
    logic [CNT_W-1:0]   cnt;
    cause_e             cause;
    logic               err_fifo, err_clash;

    assign sel      = decode_sel(cs, dack_n);
    assign wr_s     = wr && !rd;
    assign fifo_hit = sel.dma || (sel.regs && reg_addr == RA_FIFO);
    assign rd_req   = rd   && fifo_hit;
    assign wr_req   = wr_s && fifo_hit;

    assign host_pop  = rd_req && !f_empty;
    assign host_push = wr_req && !f_full;
    assign ovf       = (rd_req && f_empty) || (wr_req && f_full);

    assign dev_in_ready  = !dir_q && !f_full && !wr_req;
    assign dev_out_valid = dir_q && !f_empty && !rd_req;
    assign dev_out_data  = f_head;
    assign dev_push      = dev_in_valid && dev_in_ready;
    assign dev_pop       = dev_out_valid && dev_out_ready;

    assign f_push  = host_push || dev_push;
    assign f_pdata = host_push ? wdata : dev_in_data;
    assign f_pop   = host_pop || dev_pop;

    assign dma_ok   = sel.dma && (host_pop || host_push);
    assign pio_ok   = sel.regs && (reg_addr == RA_FIFO) && (host_pop || host_push);
    assign stat_clr = sel.regs && rd && (reg_addr == RA_STAT);

    assign dreq = dir_q ? !f_full : !f_empty;

    always_ff @(posedge clk) begin
        if (rst)                                           dir_q <= 1'b0;
        else if (sel.regs && wr_s && reg_addr == RA_CTRL)  dir_q <= wdata[0];
    end

    xfp_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .push(f_push), .pdata(f_pdata), .pop(f_pop),
        .head(f_head), .full(f_full), .empty(f_empty)
    );

    xfp_xcount #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst),
        .load_lo(sel.regs && wr_s && reg_addr == RA_CNT_LO),
        .load_hi(sel.regs && wr_s && reg_addr == RA_CNT_HI),
        .din(wdata), .dec(dma_ok),
        .cnt(cnt), .tc(tc)
    );

    xfp_irq u_irq (
        .clk(clk), .rst(rst),
        .phase_i(phase_chg), .tc_i(tc), .pio_i(pio_ok), .clr_i(stat_clr),
        .ovf_i(ovf), .clash_i(sel.clash),
        .cause(cause), .err_fifo(err_fifo), .err_clash(err_clash), .irq(irq)
    );

    always_comb begin
        rdata = '0;
        if (rd && sel.dma) begin
            rdata = f_empty ? '0 : f_head;
        end else if (rd && sel.regs) begin
            case (reg_addr)
                RA_CNT_LO: rdata = cnt[DATA_W-1:0];
                RA_CNT_HI: rdata = cnt[CNT_W-1:DATA_W];
                RA_FIFO:   rdata = f_empty ? '0 : f_head;
                RA_CTRL:   rdata = {{(DATA_W-1){1'b0}}, dir_q};
                RA_STAT:   rdata = {err_fifo, err_clash, {(DATA_W-4){1'b0}}, cause};
                default:   rdata = '0;
            endcase
        end
    end

    // R10
    ignored_access_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && f_empty && !dev_push) |=> f_empty);

    // R2
    req_in_chk: assert property (@(posedge clk) disable iff (rst)
        (!dir_q && dev_push && !f_pop) |=> dreq);

endmodule

// File: tb/tb_xfer_port.sv
`timescale 1ns/1ps
module tb_xfer_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 0, rd = 0, wr = 0, dack_n = 1;
    logic [3:0] reg_addr = '0;
    logic [7:0] wdata = '0, dev_in_data = '0;
    logic       dev_in_valid = 0, dev_out_ready = 0, phase_chg = 0;
    logic [7:0] rdata, dev_out_data;
    logic       dreq, dev_in_ready, dev_out_valid, irq;

    int    nchk = 0, nerr = 0;
    string cur_req = "R11";

    // reference model state
    logic [7:0] mq[$];
    int         mcnt = 0, mcause = 0;
    bit         mdir = 0, merr = 0, mclash = 0;

    always #2 clk = ~clk;

    xfer_port dut (
        .clk(clk), .rst(rst), .cs(cs), .reg_addr(reg_addr), .rd(rd), .wr(wr),
        .wdata(wdata), .rdata(rdata), .dack_n(dack_n), .dreq(dreq),
        .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
        .phase_chg(phase_chg), .irq(irq)
    );

    task automatic chk(input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    function automatic bit hit();
        return (!cs && !dack_n) || (cs && dack_n && reg_addr == 4'd2);
    endfunction

    task automatic compare();
        bit full  = (mq.size() == 16);
        bit empty = (mq.size() == 0);
        bit rdq   = rd && hit();
        bit wrq   = wr && !rd && hit();
        int er    = 0;
        if (rd && !cs && !dack_n) er = empty ? 0 : mq[0];
        else if (rd && cs && dack_n) begin
            case (reg_addr)
                4'd0: er = mcnt & 8'hff;
                4'd1: er = (mcnt >> 8) & 8'hff;
                4'd2: er = empty ? 0 : mq[0];
                4'd3: er = mdir;
                4'd4: er = (merr << 7) | (mclash << 6) | mcause;
                default: er = 0;
            endcase
        end
        chk("rdata", rdata, er);
        chk("dreq", dreq, mdir ? !full : !empty);
        chk("irq", irq, mcause != 0);
        chk("dev_in_ready", dev_in_ready, !mdir && !full && !wrq);
        chk("dev_out_valid", dev_out_valid, mdir && !empty && !rdq);
        if (mdir && !empty) chk("dev_out_data", dev_out_data, mq[0]);
    endtask

    task automatic model_update();
        bit dma   = !cs && !dack_n;
        bit rg    = cs && dack_n;
        bit clash = cs && !dack_n;
        bit rdq   = rd && hit();
        bit wrq   = wr && !rd && hit();
        bit empty0 = (mq.size() == 0), full0 = (mq.size() == 16);
        bit hpop  = rdq && !empty0, hpush = wrq && !full0;
        bit ovf   = (rdq && empty0) || (wrq && full0);
        bit dpush = dev_in_valid && !mdir && !full0 && !wrq;
        bit dpop  = dev_out_ready && mdir && !empty0 && !rdq;
        bit tc = 0, pio, clr;
        int nc;
        if (hpop || dpop) void'(mq.pop_front());
        if (hpush) mq.push_back(wdata);
        else if (dpush) mq.push_back(dev_in_data);
        if (dma && (hpop || hpush) && mcnt != 0) begin
            tc = (mcnt == 1);
            mcnt--;
        end
        if (rg && wr && !rd) begin
            case (reg_addr)
                4'd0: mcnt = (mcnt & 16'hff00) | wdata;
                4'd1: mcnt = (mcnt & 16'h00ff) | (int'(wdata) << 8);
                4'd3: mdir = wdata[0];
                default: ;
            endcase
        end
        pio = rg && reg_addr == 4'd2 && (hpop || hpush);
        clr = rg && rd && reg_addr == 4'd4;
        nc  = phase_chg ? 3 : tc ? 2 : pio ? 1 : 0;
        mcause = clr ? nc : (nc > mcause ? nc : mcause);
        merr   = (merr && !clr) || ovf;
        mclash = (mclash && !clr) || clash;
    endtask

    task automatic step();
        #1 compare();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle();
        cs = 0; rd = 0; wr = 0; dack_n = 1; reg_addr = '0; wdata = '0;
        dev_in_valid = 0; dev_out_ready = 0; phase_chg = 0;
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
        cs = 1; reg_addr = a; wr = 1; wdata = d; step(); idle();
    endtask

    task automatic reg_rd(input logic [3:0] a);
        cs = 1; reg_addr = a; rd = 1; step(); idle();
    endtask

    task automatic dma_rd();
        dack_n = 0; rd = 1; step(); idle();
    endtask

    task automatic dma_wr(input logic [7:0] d);
        dack_n = 0; wr = 1; wdata = d; step(); idle();
    endtask

    task automatic dev_send(input logic [7:0] d);
        dev_in_valid = 1; dev_in_data = d; step(); idle();
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired during %s", cur_req);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R11: reset state
        cur_req = "R11";
        step();
        reg_rd(4'd4); reg_rd(4'd0); reg_rd(4'd1); reg_rd(4'd3);

        // R2 R6 R7 R9: device-to-host transfer paced by dreq
        cur_req = "R6";
        reg_wr(4'd3, 8'h00);
        reg_wr(4'd0, 8'h05); reg_wr(4'd1, 8'h00);
        reg_rd(4'd0); reg_rd(4'd1);
        cur_req = "R2";
        for (int i = 0; i < 5; i++) dev_send(8'h30 + 8'(i));
        cur_req = "R4";
        for (int i = 0; i < 4; i++) dma_rd();
        reg_rd(4'd0);
        cur_req = "R7";
        dma_rd(); step();
        cur_req = "R9";
        reg_rd(4'd4); step();

        // R1 R5 R10: overfill from device side, drain by register reads
        cur_req = "R1";
        dev_in_valid = 1;
        for (int i = 0; i < 20; i++) begin dev_in_data = 8'h80 + 8'(i); step(); end
        idle();
        cur_req = "R5";
        for (int i = 0; i < 16; i++) reg_rd(4'd2);
        cur_req = "R10";
        reg_rd(4'd2); dma_rd(); reg_rd(4'd0); reg_rd(4'd4);

        // R3 R10: host-to-device, overfill through the acknowledge port
        cur_req = "R3";
        reg_wr(4'd3, 8'h01);
        reg_wr(4'd0, 8'h20); reg_wr(4'd1, 8'h01);
        for (int i = 0; i < 17; i++) dma_wr(8'hc0 + 8'(i));
        cur_req = "R10";
        reg_rd(4'd0); reg_rd(4'd4);
        cur_req = "R3";
        dev_out_ready = 1;
        for (int i = 0; i < 18; i++) step();
        idle();
        cur_req = "R5";
        reg_wr(4'd2, 8'h5a); reg_rd(4'd4);
        dev_out_ready = 1; step(); idle();

        // R4: chip select together with acknowledge
        cur_req = "R4";
        reg_wr(4'd3, 8'h00);
        dev_send(8'h77);
        cs = 1; dack_n = 0; rd = 1; reg_addr = 4'd2; step(); idle();
        reg_rd(4'd4); dma_rd(); reg_rd(4'd4);

        // R8: phase change coinciding with terminal count, then priority hold
        cur_req = "R8";
        reg_wr(4'd0, 8'h01); reg_wr(4'd1, 8'h00);
        dev_send(8'h11);
        dack_n = 0; rd = 1; phase_chg = 1; step(); idle();
        reg_rd(4'd4);
        reg_wr(4'd0, 8'h02);
        dev_send(8'h12); dev_send(8'h13);
        phase_chg = 1; step(); idle();
        dma_rd(); dma_rd(); reg_rd(4'd2);
        reg_rd(4'd4); step();
        reg_rd(4'd4);

        summary();
        $finish;
    end
endmodule